// File: doc/BRIEF.md
# ALU with condition flags

This block is a 16-bit arithmetic and logic unit paired with a registered bank of four condition flags: zero (Z), negative (N), carry (C) and overflow (O). A 4-bit operation code selects one of twelve operations: bitwise logic, single-bit logical shifts, add and subtract with or without a carry input, and single-bit rotates through the carry. The result is produced combinationally from two operands and the current carry value supplied by the surrounding pipeline.

Each operation owns a fixed subset of the flags. The block presents the next flag values on `flags_nxt`, with flags outside the subset carried over from the register. The register `flags_q` loads them on a clock edge only when `upd_en` is high. A separate `imm_add` request forces an addition of the two operands that refreshes N and Z only, so an add-immediate path can share the adder without disturbing C and O.

Top module: `alu_flags_unit`

## Requirements
- R1: Operation codes 0, 1, 6 and 7 give and, or, xor and not; `not` uses only `opa`. These four update only N and Z.
- R2: Code 2 is a logical left shift by one and code 3 a logical right shift by one, both filling with zero and using only `opa`. C receives the bit shifted out (bit 15 for left, bit 0 for right), N and Z are updated, and O is kept.
- R3: Code 4 adds and code 5 subtracts (`opa - opb`). All four flags are updated. For add, C is the carry out of bit 15. For subtract, C is set when a borrow occurs. O is set on two's-complement signed overflow.
- R4: Code 8 is `opa + opb + cin` and code 9 is `opa - opb - cin`. The C and O rules of R3 apply, and the borrow counts `cin`.
- R5: Code 10 rotates `opa` left one place with `cin` entering bit 0. Code 11 rotates it right with `cin` entering bit 15. Both update only N and Z.
- R6: Whenever Z or N is updated, Z is 1 exactly when the 16-bit result is zero, and N equals result bit 15.
- R7: Codes 12 to 15 give a zero result and leave all four flags unchanged.
- R8: With `imm_add` high the result is `opa + opb` whatever `op` is. Only N and Z are updated, and C and O keep their values.
- R9: `flags_nxt` and `flags_q` use bit 0 for Z, bit 1 for N, bit 2 for C and bit 3 for O. `flags_q` takes the value of `flags_nxt` at a rising clock edge when `upd_en` is high. Otherwise it holds.
- R10: A synchronous reset (`rst` high at a rising edge) clears all four flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| upd_en | input | 1 | Write `flags_nxt` into the flag register at the next edge |
| imm_add | input | 1 | Force an add that refreshes only N and Z |
| op | input | 4 | Operation code |
| opa | input | 16 | First operand |
| opb | input | 16 | Second operand |
| cin | input | 1 | Carry value used by codes 8 to 11 |
| result | output | 16 | Combinational result |
| flags_nxt | output | 4 | Next flag values {O,C,N,Z} |
| flags_q | output | 4 | Registered flags {O,C,N,Z} |

## Verification
The hardest behaviour to show from the ports is that an operation leaves C or O alone. After reset both flags are zero, so an operation that wrongly cleared them would look correct. Each scenario that checks preservation therefore first commits an add of 0xFFFF and 0x8000, which sets C and O together. The bitwise, shift, rotate, immediate-add or unused code under test then runs on that state, and the bench checks that the kept bits still read 1. The same preload is repeated with opposite values so that a flag forced to 1 is also caught.

// File: rtl/alu_flags_pkg.sv
package alu_flags_pkg;

   localparam int FLAG_CNT = 4;
   localparam int FLG_Z    = 0;
   localparam int FLG_N    = 1;
   localparam int FLG_C    = 2;
   localparam int FLG_O    = 3;

   typedef enum logic [3:0] {
      OP_AND = 4'd0,
      OP_OR  = 4'd1,
      OP_SHL = 4'd2,
      OP_SHR = 4'd3,
      OP_ADD = 4'd4,
      OP_SUB = 4'd5,
      OP_XOR = 4'd6,
      OP_NOT = 4'd7,
      OP_ADC = 4'd8,
      OP_SBC = 4'd9,
      OP_ROL = 4'd10,
      OP_ROR = 4'd11
   } alu_op_e;

   localparam logic [FLAG_CNT-1:0] MASK_NONE = 4'b0000;
   localparam logic [FLAG_CNT-1:0] MASK_NZ   = 4'b0011;
   localparam logic [FLAG_CNT-1:0] MASK_CNZ  = 4'b0111;
   localparam logic [FLAG_CNT-1:0] MASK_ALL  = 4'b1111;

   function automatic logic [FLAG_CNT-1:0] op_flag_mask(input logic [3:0] code);
      case (code)
         OP_AND, OP_OR, OP_XOR, OP_NOT, OP_ROL, OP_ROR: op_flag_mask = MASK_NZ;
         OP_SHL, OP_SHR:                                 op_flag_mask = MASK_CNZ;
         OP_ADD, OP_SUB, OP_ADC, OP_SBC:                 op_flag_mask = MASK_ALL;
         default:                                        op_flag_mask = MASK_NONE;
      endcase
   endfunction

endpackage

// File: rtl/alu_core.sv
module alu_core
   import alu_flags_pkg::*;
#(
   parameter int WIDTH = 16
) (
   input  logic [3:0]       code,
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   input  logic             ci,
   output logic [WIDTH-1:0] res,
   output logic             co,
   output logic             ov
);
   localparam int MSB = WIDTH - 1;

   logic             is_sub;
   logic             add_ci;
   logic [WIDTH-1:0] b_eff;
   logic [WIDTH:0]   sum;

   // one adder serves all four arithmetic codes; subtract = add of the inverse
   always_comb begin
      is_sub = (code == OP_SUB) || (code == OP_SBC);
      case (code)
         OP_SUB:  add_ci = 1'b1;
         OP_ADC:  add_ci = ci;
         OP_SBC:  add_ci = ~ci;
         default: add_ci = 1'b0;
      endcase
      b_eff = is_sub ? ~b : b;
      sum   = {1'b0, a} + {1'b0, b_eff} + {{WIDTH{1'b0}}, add_ci};
   end

   always_comb begin
      res = '0;
      co  = 1'b0;
      ov  = 1'b0;
      case (code)
         OP_AND: res = a & b;
         OP_OR:  res = a | b;
         OP_XOR: res = a ^ b;
         OP_NOT: res = ~a;
         OP_SHL: begin
            res = {a[MSB-1:0], 1'b0};
            co  = a[MSB];
         end
         OP_SHR: begin
            res = {1'b0, a[MSB:1]};
            co  = a[0];
         end
         OP_ROL: res = {a[MSB-1:0], ci};
         OP_ROR: res = {ci, a[MSB:1]};
         OP_ADD, OP_SUB, OP_ADC, OP_SBC: begin
            res = sum[MSB:0];
            co  = is_sub ? ~sum[WIDTH] : sum[WIDTH];
            ov  = (a[MSB] == b_eff[MSB]) && (sum[MSB] != a[MSB]);
         end
         default: res = '0;
      endcase
   end
endmodule

// File: rtl/alu_flag_reg.sv
module alu_flag_reg
   import alu_flags_pkg::*;
#(
   parameter int NFLAGS = FLAG_CNT
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              en,
   input  logic [NFLAGS-1:0] mask,
   input  logic [NFLAGS-1:0] calc,
   output logic [NFLAGS-1:0] nxt,
   output logic [NFLAGS-1:0] q
);
   for (genvar i = 0; i < NFLAGS; i++) begin : g_flag
      assign nxt[i] = mask[i] ? calc[i] : q[i];

      always_ff @(posedge clk) begin
         if (rst)     q[i] <= 1'b0;
         else if (en) q[i] <= nxt[i];
      end
   end
endmodule

// File: rtl/alu_flags_unit.sv
module alu_flags_unit
   import alu_flags_pkg::*;
#(
   parameter int WIDTH = 16
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             upd_en,
   input  logic             imm_add,
   input  logic [3:0]       op,
   input  logic [WIDTH-1:0] opa,
   input  logic [WIDTH-1:0] opb,
   input  logic             cin,
   output logic [WIDTH-1:0] result,
   output logic [3:0]       flags_nxt,
   output logic [3:0]       flags_q
);
   if (WIDTH < 2) begin : g_width_chk
      $error("alu_flags_unit: WIDTH must be at least 2");
   end

   logic [3:0]          eff_op;
   logic [FLAG_CNT-1:0] upd_mask;
   logic [FLAG_CNT-1:0] calc;
   logic                core_co;
   logic                core_ov;

   assign eff_op   = imm_add ? OP_ADD : op;
   assign upd_mask = imm_add ? MASK_NZ : op_flag_mask(op);

   alu_core #(.WIDTH(WIDTH)) u_core (
      .code (eff_op),
      .a    (opa),
      .b    (opb),
      .ci   (cin),
      .res  (result),
      .co   (core_co),
      .ov   (core_ov)
   );

   always_comb begin
      calc        = '0;
      calc[FLG_Z] = (result == '0);
      calc[FLG_N] = result[WIDTH-1];
      calc[FLG_C] = core_co;
      calc[FLG_O] = core_ov;
   end

   alu_flag_reg #(.NFLAGS(FLAG_CNT)) u_flags (
      .clk  (clk),
      .rst  (rst),
      .en   (upd_en),
      .mask (upd_mask),
      .calc (calc),
      .nxt  (flags_nxt),
      .q    (flags_q)
   );
endmodule

// File: rtl/alu_flags_checker.sv
module alu_flags_checker #(
   parameter int WIDTH = 16
) (
   input logic             clk,
   input logic             rst,
   input logic             upd_en,
   input logic             imm_add,
   input logic [3:0]       op,
   input logic [WIDTH-1:0] result,
   input logic [3:0]       flags_nxt,
   input logic [3:0]       flags_q
);
   assert_reset_clears_R10: assert property (@(posedge clk)
      rst |=> (flags_q == 4'b0000));

   assert_hold_when_idle_R9: assert property (@(posedge clk) disable iff (rst)
      !upd_en |=> $stable(flags_q));

   assert_load_when_enabled_R9: assert property (@(posedge clk) disable iff (rst)
      upd_en |=> (flags_q == $past(flags_nxt)));

   assert_logic_keeps_co_R1: assert property (@(posedge clk) disable iff (rst)
      (!imm_add && (op == 4'd0 || op == 4'd1 || op == 4'd6 || op == 4'd7))
         |-> (flags_nxt[3:2] == flags_q[3:2]));

   assert_shift_keeps_o_R2: assert property (@(posedge clk) disable iff (rst)
      (!imm_add && (op == 4'd2 || op == 4'd3)) |-> (flags_nxt[3] == flags_q[3]));

   assert_rotate_keeps_co_R5: assert property (@(posedge clk) disable iff (rst)
      (!imm_add && (op == 4'd10 || op == 4'd11)) |-> (flags_nxt[3:2] == flags_q[3:2]));

   assert_zero_tracks_result_R6: assert property (@(posedge clk) disable iff (rst)
      (imm_add || op < 4'd12) |-> (flags_nxt[0] == (result == '0)
                                   && flags_nxt[1] == result[WIDTH-1]));

   assert_unused_code_R7: assert property (@(posedge clk) disable iff (rst)
      (!imm_add && op >= 4'd12) |-> (result == '0 && flags_nxt == flags_q));

   assert_imm_keeps_co_R8: assert property (@(posedge clk) disable iff (rst)
      imm_add |-> (flags_nxt[3:2] == flags_q[3:2]));
endmodule

bind alu_flags_unit alu_flags_checker #(.WIDTH(WIDTH)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .upd_en    (upd_en),
   .imm_add   (imm_add),
   .op        (op),
   .result    (result),
   .flags_nxt (flags_nxt),
   .flags_q   (flags_q)
);

// File: tb/alu_flags_unit_bench.sv
module alu_flags_unit_bench;
   logic        clk = 1'b0;
   logic        rst, upd_en, imm_add, cin;
   logic [3:0]  op;
   logic [15:0] opa, opb;
   logic [15:0] result;
   logic [3:0]  flags_nxt, flags_q;

   int n_chk = 0;
   int n_bad = 0;
   logic [3:0] model_q;

   always #10 clk = ~clk;

   alu_flags_unit u_alu_flags_unit (
      .clk(clk), .rst(rst), .upd_en(upd_en), .imm_add(imm_add), .op(op),
      .opa(opa), .opb(opb), .cin(cin), .result(result),
      .flags_nxt(flags_nxt), .flags_q(flags_q)
   );

   task automatic check(input string req, input string what, input logic [15:0] got, input logic [15:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
      end
   endtask

   // reference model built from the requirements; flags as {O,C,N,Z}
   task automatic model(input logic [3:0] c, input logic [15:0] a, input logic [15:0] b,
                        input logic ci, input logic imm,
                        output logic [15:0] r, output logic [3:0] nxt);
      int sa, sb, sr;
      logic [16:0] w;
      logic [3:0] m;
      logic fc, fo;
      sa = $signed(a); sb = $signed(b);
      fc = 1'b0; fo = 1'b0; r = 16'h0; m = 4'b0000;
      if (imm) begin
         w = 17'(a) + 17'(b); r = w[15:0]; m = 4'b0011;
      end else case (c)
         4'd0:  begin r = a & b; m = 4'b0011; end
         4'd1:  begin r = a | b; m = 4'b0011; end
         4'd6:  begin r = a ^ b; m = 4'b0011; end
         4'd7:  begin r = ~a;    m = 4'b0011; end
         4'd2:  begin r = a << 1; fc = a[15]; m = 4'b0111; end
         4'd3:  begin r = a >> 1; fc = a[0];  m = 4'b0111; end
         4'd10: begin r = {a[14:0], ci}; m = 4'b0011; end
         4'd11: begin r = {ci, a[15:1]}; m = 4'b0011; end
         4'd4, 4'd8: begin
            w  = 17'(a) + 17'(b) + ((c == 4'd8) ? 17'(ci) : 17'd0);
            sr = sa + sb + ((c == 4'd8) ? int'(ci) : 0);
            r = w[15:0]; fc = w[16]; fo = (sr > 32767) || (sr < -32768); m = 4'b1111;
         end
         4'd5, 4'd9: begin
            w  = 17'(a) - 17'(b) - ((c == 4'd9) ? 17'(ci) : 17'd0);
            sr = sa - sb - ((c == 4'd9) ? int'(ci) : 0);
            r = w[15:0]; fc = w[16]; fo = (sr > 32767) || (sr < -32768); m = 4'b1111;
         end
         default: begin r = 16'h0; m = 4'b0000; end
      endcase
      nxt[0] = m[0] ? (r == 16'h0) : model_q[0];
      nxt[1] = m[1] ? r[15]        : model_q[1];
      nxt[2] = m[2] ? fc           : model_q[2];
      nxt[3] = m[3] ? fo           : model_q[3];
   endtask

   task automatic apply(input string req, input logic [3:0] c, input logic [15:0] a,
                        input logic [15:0] b, input logic ci, input logic imm, input logic en);
      logic [15:0] er;
      logic [3:0]  en_nxt;
      @(negedge clk);
      op = c; opa = a; opb = b; cin = ci; imm_add = imm; upd_en = en;
      #2;
      model(c, a, b, ci, imm, er, en_nxt);
      check(req, "result", result, er);
      check(req, "flags_nxt", {12'h0, flags_nxt}, {12'h0, en_nxt});
      @(posedge clk); #2;
      if (en) model_q = en_nxt;
      check(req, "flags_q", {12'h0, flags_q}, {12'h0, model_q});
   endtask

   // preload C=1,O=1,N=0,Z=0 via 0xFFFF+0x8000
   task automatic preload_co();
      apply("R3", 4'd4, 16'hFFFF, 16'h8000, 1'b0, 1'b0, 1'b1);
      check("R3", "preload", {12'h0, flags_q}, 16'h000C);
   endtask

   task automatic t_reset();
      apply("R3", 4'd4, 16'h7FFF, 16'h0001, 1'b0, 1'b0, 1'b1);
      @(negedge clk); rst = 1'b1; upd_en = 1'b1;
      @(posedge clk); #2; rst = 1'b0; model_q = 4'b0000;
      check("R10", "flags after reset", {12'h0, flags_q}, 16'h0000);
   endtask

   task automatic t_bitwise();
      preload_co();
      apply("R1", 4'd0, 16'hF0F0, 16'h0FF0, 1'b1, 1'b0, 1'b1);
      apply("R1", 4'd1, 16'h0000, 16'h0000, 1'b0, 1'b0, 1'b1);
      apply("R1", 4'd6, 16'hAAAA, 16'h5555, 1'b0, 1'b0, 1'b1);
      apply("R1", 4'd7, 16'h00FF, 16'h1234, 1'b0, 1'b0, 1'b1);
      apply("R1", 4'd7, 16'h00FF, 16'hFFFF, 1'b0, 1'b0, 1'b1);
      check("R1", "C,O kept", {14'h0, flags_q[3:2]}, 16'h0003);
   endtask

   task automatic t_shifts();
      preload_co();
      apply("R2", 4'd2, 16'h8001, 16'hFFFF, 1'b1, 1'b0, 1'b1);
      apply("R2", 4'd2, 16'h4000, 16'h0000, 1'b0, 1'b0, 1'b1);
      apply("R2", 4'd3, 16'h0001, 16'h1234, 1'b1, 1'b0, 1'b1);
      apply("R2", 4'd3, 16'h8000, 16'h0000, 1'b0, 1'b0, 1'b1);
      check("R2", "O kept", {15'h0, flags_q[3]}, 16'h0001);
   endtask

   task automatic t_addsub();
      apply("R3", 4'd4, 16'h7FFF, 16'h0001, 1'b1, 1'b0, 1'b1);
      apply("R3", 4'd4, 16'hFFFF, 16'h0001, 1'b0, 1'b0, 1'b1);
      apply("R3", 4'd5, 16'h0003, 16'h0005, 1'b0, 1'b0, 1'b1);
      apply("R3", 4'd5, 16'h8000, 16'h0001, 1'b1, 1'b0, 1'b1);
      apply("R6", 4'd5, 16'h1234, 16'h1234, 1'b0, 1'b0, 1'b1);
   endtask

   task automatic t_carry_chain();
      apply("R4", 4'd8, 16'hFFFF, 16'h0000, 1'b1, 1'b0, 1'b1);
      apply("R4", 4'd8, 16'h7FFE, 16'h0001, 1'b1, 1'b0, 1'b1);
      apply("R4", 4'd8, 16'h1000, 16'h2000, 1'b0, 1'b0, 1'b1);
      apply("R4", 4'd9, 16'h0005, 16'h0005, 1'b1, 1'b0, 1'b1);
      apply("R4", 4'd9, 16'h0005, 16'h0004, 1'b1, 1'b0, 1'b1);
      apply("R4", 4'd9, 16'h8000, 16'h0000, 1'b1, 1'b0, 1'b1);
   endtask

   task automatic t_rotate();
      preload_co();
      apply("R5", 4'd10, 16'h8000, 16'hFFFF, 1'b1, 1'b0, 1'b1);
      apply("R5", 4'd10, 16'h8000, 16'h0000, 1'b0, 1'b0, 1'b1);
      apply("R5", 4'd11, 16'h0001, 16'h0000, 1'b1, 1'b0, 1'b1);
      apply("R5", 4'd11, 16'h0002, 16'h0000, 1'b0, 1'b0, 1'b1);
      check("R5", "C,O kept", {14'h0, flags_q[3:2]}, 16'h0003);
   endtask

   task automatic t_unused();
      preload_co();
      for (int c = 12; c < 16; c++)
         apply("R7", 4'(c), 16'hFFFF, 16'hFFFF, 1'b1, 1'b0, 1'b1);
      check("R7", "flags kept", {12'h0, flags_q}, 16'h000C);
      apply("R3", 4'd5, 16'h0001, 16'h0001, 1'b0, 1'b0, 1'b1);
      apply("R7", 4'd13, 16'h8000, 16'h0000, 1'b0, 1'b0, 1'b1);
      check("R7", "flags kept zero", {12'h0, flags_q}, 16'h0001);
   endtask

   task automatic t_immadd();
      preload_co();
      apply("R8", 4'd5, 16'hFFFF, 16'h0001, 1'b0, 1'b1, 1'b1);
      apply("R8", 4'd0, 16'h7FFF, 16'h0001, 1'b0, 1'b1, 1'b1);
      check("R8", "C,O kept", {14'h0, flags_q[3:2]}, 16'h0003);
      apply("R3", 4'd4, 16'h0001, 16'h0001, 1'b0, 1'b0, 1'b1);
      apply("R8", 4'd15, 16'hFFFF, 16'hFFFF, 1'b0, 1'b1, 1'b1);
      check("R8", "C,O kept clear", {14'h0, flags_q[3:2]}, 16'h0000);
   endtask

   task automatic t_hold();
      preload_co();
      apply("R9", 4'd5, 16'h0000, 16'h0000, 1'b0, 1'b0, 1'b0);
      apply("R9", 4'd1, 16'h0000, 16'h0000, 1'b0, 1'b0, 1'b0);
      check("R9", "held", {12'h0, flags_q}, 16'h000C);
      apply("R9", 4'd1, 16'h0000, 16'h0000, 1'b0, 1'b0, 1'b1);
      check("R9", "loaded", {12'h0, flags_q}, 16'h000D);
   endtask

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      #(20 * 200000);
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      rst = 1'b1; upd_en = 1'b0; imm_add = 1'b0; cin = 1'b0;
      op = 4'd0; opa = 16'h0; opb = 16'h0; model_q = 4'b0000;
      repeat (2) @(posedge clk);
      #2;
      check("R10", "flags at reset", {12'h0, flags_q}, 16'h0000);
      rst = 1'b0;
      t_bitwise();
      t_shifts();
      t_addsub();
      t_carry_chain();
      t_rotate();
      t_unused();
      t_immadd();
      t_hold();
      t_reset();
      finish_run();
   end
endmodule